// File: doc/BRIEF.md
# Serial Port Control and Status Register Front End

This block is the software-facing register file of a simple serial port. A byte-wide register bus (six-bit offset, read and write strobes, combinational read data) reaches two mode registers behind a pointer, a status byte, an interrupt status and mask pair, two baud-divider bytes, a command port, a transmit holding register and a small receive FIFO. One level-sensitive interrupt line leaves the block.

The bit-level serializer sits outside. It takes transmit bytes through a valid/ready handshake and offers received bytes through a push strobe, gated by an accept output. A line-break event enters on its own strobe. A command byte holds three fields that are decoded together: a miscellaneous action, a transmitter action and a receiver action. The fields apply in that order within one write.

Top module: `sport_csr`

## Requirements
- R1: After reset, both mode registers, the interrupt status and the mask read 0x00, both directions are disabled, the FIFO is empty, and status (offset 0x04) reads 0x08.
- R2: Offset 0x00 reads and writes the mode register chosen by a pointer. A write advances the pointer to the second register, where it stays. A read never moves it. Command bits 6:4 equal to 1 return it to the first register.
- R3: Status bit 0 is set while the FIFO holds a byte, bit 1 while it holds DEPTH bytes, bit 2 while the transmitter is enabled, and bit 3 while the holding register is empty. Bits 7:4 read 0. A read of 0x0C pops the oldest byte, and an empty FIFO reads 0x00.
- R4: Command bits 3:2 and bits 1:0 drive the transmitter and the receiver respectively: 1 enables, 2 disables, 0 does nothing. These fields take effect after the bits 6:4 action of the same write.
- R5: Bits 6:4 equal to 2 disable the receiver and empty the FIFO. Code 3 disables the transmitter and drops any pending byte, so transmit-empty is set. Code 5 clears the break flag. Codes 0, 4, 6 and 7 change nothing.
- R6: A write to 0x0C loads the holding register and clears transmit-empty. While the transmitter is enabled and a byte is pending, tx_valid is high with tx_data stable. A cycle with tx_ready high hands the byte over and sets transmit-empty again.
- R7: Interrupt status (read at 0x14) has bit 0 equal to status bit 2 and bit 2 equal to the break flag. Bit 1 equals status bit 1 when bit 6 of the first mode register is set, and status bit 0 otherwise.
- R8: A write to 0x14 sets the mask. irq is high exactly when interrupt status AND mask is non-zero, valid the cycle after any state change.
- R9: rx_accept is high while the receiver is enabled and the FIFO is not full. A push while it is low is dropped.
- R10: Code 3 in the transmitter or receiver field leaves that enable unchanged and raises cmd_err for exactly one cycle after the write.
- R11: A break strobe sets the break flag and queues a 0x00 byte, even with the receiver disabled. When the FIFO is full, that byte replaces the newest entry.
- R12: Offsets 0x18 and 0x1C are read/write baud-divider bytes that reset to 0. Writes to 0x04 and 0x10 have no effect. 0x10 and unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the FIFO at 0x0C) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| rx_push | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Line break event strobe |
| rx_accept | output | 1 | Receiver able to take a byte |
| tx_valid | output | 1 | Holding register offers a byte |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| irq | output | 1 | Level interrupt |
| cmd_err | output | 1 | One-cycle pulse on a reserved command code |

## Verification
The hardest state to reach is a break arriving on a full FIFO. That needs the receiver enabled, DEPTH minus one pushes and a break in the same burst, and only the fourth pop shows the overwrite. The bench fills the FIFO this way and drains it through the register port, so it checks both the order of the bytes and the replaced tail. A second hard case is a byte pending while the transmitter is disabled. The bench writes data while disabled, re-enables the transmitter, and then issues the transmitter-reset command, checking that the offer appears and then vanishes.

// File: rtl/sport_csr_pkg.sv
package sport_csr_pkg;
  localparam logic [5:0] OFS_MODE = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_CMD  = 6'h08;
  localparam logic [5:0] OFS_DATA = 6'h0C;
  localparam logic [5:0] OFS_AUX  = 6'h10;
  localparam logic [5:0] OFS_INT  = 6'h14;
  localparam logic [5:0] OFS_BDH  = 6'h18;
  localparam logic [5:0] OFS_BDL  = 6'h1C;

  typedef enum logic [1:0] {DIR_NOP = 2'd0, DIR_ON = 2'd1, DIR_OFF = 2'd2, DIR_BAD = 2'd3} dir_act_e;

  typedef enum logic [2:0] {
    MSC_NOP = 3'd0, MSC_PTR = 3'd1, MSC_RXRST = 3'd2, MSC_TXRST = 3'd3,
    MSC_ERR = 3'd4, MSC_BRKCLR = 3'd5, MSC_BRKON = 3'd6, MSC_BRKOFF = 3'd7
  } misc_act_e;

  typedef struct packed {
    misc_act_e misc;
    dir_act_e  tx;
    dir_act_e  rx;
  } cmd_t;

  // status byte: {4'b0, tx_empty, tx_rdy, fifo_full, rx_rdy}
  function automatic logic [7:0] pack_status(logic rx_rdy, logic full, logic tx_rdy, logic tx_empty);
    return {4'b0000, tx_empty, tx_rdy, full, rx_rdy};
  endfunction

  function automatic logic [7:0] pack_isr(logic [7:0] stat, logic full_sel, logic brk);
    logic rx_src;
    rx_src = full_sel ? stat[1] : stat[0];
    return {5'b00000, brk, rx_src, stat[2]};
  endfunction
endpackage

// File: rtl/sport_cmd_decode.sv
module sport_cmd_decode
  import sport_csr_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_t       cmd,
  output logic       bad_code
);
  always_comb begin
    cmd.misc = misc_act_e'(cmd_byte[6:4]);
    cmd.tx   = dir_act_e'(cmd_byte[3:2]);
    cmd.rx   = dir_act_e'(cmd_byte[1:0]);
    bad_code = (cmd.tx == DIR_BAD) || (cmd.rx == DIR_BAD);
  end
endmodule

// File: rtl/sport_rx_fifo.sv
module sport_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] ent_q [DEPTH];
  logic [CW-1:0]    cnt_after_pop;
  logic [CW-1:0]    wr_idx;

  always_comb begin
    cnt_after_pop = count - CW'(pop);
    // a push into a full FIFO (no pop) replaces the newest entry
    wr_idx = (cnt_after_pop == CW'(DEPTH)) ? CW'(DEPTH - 1) : cnt_after_pop;
  end

  assign head = ent_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (push && wr_idx == CW'(i)) ent_q[i] <= din;
      else if (pop) ent_q[i] <= (i == DEPTH - 1) ? ent_q[i] : ent_q[(i == DEPTH - 1) ? i : i + 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (flush) count <= '0;
    else if (push && cnt_after_pop != CW'(DEPTH)) count <= cnt_after_pop + 1'b1;
    else count <= cnt_after_pop;
  end
endmodule

// File: rtl/sport_csr.sv
module sport_csr
  import sport_csr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  input  logic       rx_break,
  output logic       rx_accept,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       irq,
  output logic       cmd_err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0] mode_q [2];
  logic       mode_ptr_q;
  logic [7:0] imr_q, bdh_q, bdl_q, hold_q;
  logic       tx_en_q, rx_en_q, tx_empty_q, brk_q, err_q;

  // named internal events
  logic       wr_cmd, wr_data, rd_data, tx_fire;
  logic       fifo_push, fifo_pop, fifo_flush;
  logic [7:0] fifo_din, fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic       fifo_full, fifo_nonempty;
  logic [7:0] stat_w, isr_w;
  cmd_t       cmd;
  logic       cmd_bad;
  logic       tx_en_n, rx_en_n;

  sport_cmd_decode u_dec (.cmd_byte(reg_wdata), .cmd(cmd), .bad_code(cmd_bad));

  assign wr_cmd  = reg_wr && reg_addr == OFS_CMD;
  assign wr_data = reg_wr && reg_addr == OFS_DATA;
  assign rd_data = reg_rd && reg_addr == OFS_DATA;

  assign fifo_full     = fifo_cnt == CW'(DEPTH);
  assign fifo_nonempty = fifo_cnt != '0;
  assign rx_accept     = rx_en_q && !fifo_full;
  assign fifo_flush    = wr_cmd && cmd.misc == MSC_RXRST;
  assign fifo_pop      = rd_data && fifo_nonempty;
  assign fifo_push     = rx_break || (rx_push && rx_accept);
  assign fifo_din      = rx_break ? 8'h00 : rx_byte;

  sport_rx_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(fifo_push),
    .din(fifo_din), .pop(fifo_pop), .head(fifo_head), .count(fifo_cnt)
  );

  assign tx_valid = tx_en_q && !tx_empty_q;
  assign tx_data  = hold_q;
  assign tx_fire  = tx_valid && tx_ready;

  assign stat_w = pack_status(fifo_nonempty, fifo_full, tx_en_q, tx_empty_q);
  assign isr_w  = pack_isr(stat_w, mode_q[0][6], brk_q);
  assign irq    = |(isr_w & imr_q);
  assign cmd_err = err_q;

  // command fields apply in order: misc, then transmitter, then receiver
  always_comb begin
    tx_en_n = tx_en_q;
    rx_en_n = rx_en_q;
    if (wr_cmd) begin
      if (cmd.misc == MSC_TXRST) tx_en_n = 1'b0;
      if (cmd.misc == MSC_RXRST) rx_en_n = 1'b0;
      if (cmd.tx == DIR_ON)  tx_en_n = 1'b1;
      if (cmd.tx == DIR_OFF) tx_en_n = 1'b0;
      if (cmd.rx == DIR_ON)  rx_en_n = 1'b1;
      if (cmd.rx == DIR_OFF) rx_en_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q[0] <= '0; mode_q[1] <= '0; mode_ptr_q <= 1'b0;
      imr_q <= '0; bdh_q <= '0; bdl_q <= '0; hold_q <= '0;
      tx_en_q <= 1'b0; rx_en_q <= 1'b0; tx_empty_q <= 1'b1;
      brk_q <= 1'b0; err_q <= 1'b0;
    end else begin
      tx_en_q <= tx_en_n;
      rx_en_q <= rx_en_n;
      err_q   <= wr_cmd && cmd_bad;
      if (reg_wr && reg_addr == OFS_MODE) begin
        mode_q[mode_ptr_q] <= reg_wdata;
        mode_ptr_q <= 1'b1;
      end
      if (wr_cmd && cmd.misc == MSC_PTR) mode_ptr_q <= 1'b0;
      if (reg_wr && reg_addr == OFS_INT) imr_q <= reg_wdata;
      if (reg_wr && reg_addr == OFS_BDH) bdh_q <= reg_wdata;
      if (reg_wr && reg_addr == OFS_BDL) bdl_q <= reg_wdata;
      if (rx_break) brk_q <= 1'b1;
      else if (wr_cmd && cmd.misc == MSC_BRKCLR) brk_q <= 1'b0;
      if (wr_data) begin
        hold_q     <= reg_wdata;
        tx_empty_q <= 1'b0;
      end else if (tx_fire || (wr_cmd && cmd.misc == MSC_TXRST)) begin
        tx_empty_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MODE: reg_rdata = mode_q[mode_ptr_q];
      OFS_STAT: reg_rdata = stat_w;
      OFS_DATA: reg_rdata = fifo_nonempty ? fifo_head : 8'h00;
      OFS_INT:  reg_rdata = isr_w;
      OFS_BDH:  reg_rdata = bdh_q;
      OFS_BDL:  reg_rdata = bdl_q;
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sport_csr_chk.sv
module sport_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       irq,
  input logic       cmd_err,
  input logic       rx_accept,
  input logic [7:0] stat_w,
  input logic       tx_en_q,
  input logic       mode_ptr_q
);
  AST_MODE_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h00) |=> mode_ptr_q); // R2
  AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_w[1] |-> stat_w[0]); // R3
  AST_TX_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h08 && reg_wdata[6:4] == 3'd3 && reg_wdata[3:2] != 2'd1)
    |=> (stat_w[3] && !stat_w[2])); // R5
  AST_TX_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(reg_wr && (reg_addr == 6'h08 || reg_addr == 6'h0C)))
    |=> (tx_valid && $stable(tx_data))); // R6
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h14 && reg_wdata == 8'h00) |=> !irq); // R8
  AST_ACCEPT_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> !stat_w[1]); // R9
  AST_BAD_TX_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 6'h08 && reg_wdata[3:2] == 2'd3 && reg_wdata[6:4] != 3'd3)
    |=> ($stable(tx_en_q) && cmd_err)); // R10
endmodule

bind sport_csr sport_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq), .cmd_err(cmd_err),
  .rx_accept(rx_accept), .stat_w(stat_w), .tx_en_q(tx_en_q), .mode_ptr_q(mode_ptr_q)
);

// File: tb/sport_csr_tb.sv
module sport_csr_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic rx_push = 1'b0, rx_break = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_accept, tx_valid, irq, cmd_err;
  logic [7:0] tx_data;

  int total = 0, bad = 0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_csr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_break(rx_break), .rx_accept(rx_accept), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq), .cmd_err(cmd_err)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (reg_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s: read 0x%02h got 0x%02h expected 0x%02h", t, reg_addr, reg_rdata, e);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(posedge clk); #1;
    rx_push = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_push = 1'b0;
  endtask

  task automatic brk();
    @(posedge clk); #1;
    rx_break = 1'b1;
    @(posedge clk); #1;
    rx_break = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk({7'b0, irq}, 8'h00, "R1 irq");
    rd(6'h04, 8'h08, "R1 status");
    rd(6'h14, 8'h00, "R1 isr");
    rd(6'h00, 8'h00, "R1 mode");
    // R2 mode pointer
    wr(6'h00, 8'hA5);
    wr(6'h00, 8'h40);
    rd(6'h00, 8'h40, "R2 second mode");
    rd(6'h00, 8'h40, "R2 read keeps ptr");
    wr(6'h08, 8'h10);
    rd(6'h00, 8'hA5, "R2 ptr reset");
    // R4 transmitter enable, R7/R8 interrupt
    wr(6'h08, 8'h04);
    rd(6'h04, 8'h0C, "R4 tx enabled status");
    rd(6'h14, 8'h01, "R7 isr tx");
    chk({7'b0, irq}, 8'h00, "R8 masked");
    wr(6'h14, 8'h01);
    chk({7'b0, irq}, 8'h01, "R8 unmasked");
    wr(6'h14, 8'h00);
    chk({7'b0, irq}, 8'h00, "R8 remasked");
    // R6 transmit handshake
    wr(6'h0C, 8'h5A);
    chk({7'b0, tx_valid}, 8'h01, "R6 offer");
    chk(tx_data, 8'h5A, "R6 data");
    rd(6'h04, 8'h04, "R6 not empty");
    chk({7'b0, tx_valid}, 8'h01, "R6 offer held");
    @(posedge clk); #1 tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    chk({7'b0, tx_valid}, 8'h00, "R6 handed over");
    rd(6'h04, 8'h0C, "R6 empty again");
    // R4 disable, pending byte, R5 transmitter reset
    wr(6'h08, 8'h08);
    rd(6'h04, 8'h08, "R4 tx disabled");
    rd(6'h14, 8'h00, "R7 isr tx off");
    wr(6'h0C, 8'h33);
    chk({7'b0, tx_valid}, 8'h00, "R6 no offer when disabled");
    rd(6'h04, 8'h00, "R6 pending status");
    wr(6'h08, 8'h04);
    chk({7'b0, tx_valid}, 8'h01, "R6 offer on enable");
    chk(tx_data, 8'h33, "R6 pending data");
    wr(6'h08, 8'h30);
    chk({7'b0, tx_valid}, 8'h00, "R5 tx reset drops");
    rd(6'h04, 8'h08, "R5 tx reset status");
    // R10 reserved codes
    wr(6'h08, 8'h04);
    wr(6'h08, 8'h0C);
    chk({7'b0, cmd_err}, 8'h01, "R10 tx reserved pulse");
    rd(6'h04, 8'h0C, "R10 tx enable kept");
    chk({7'b0, cmd_err}, 8'h00, "R10 pulse one cycle");
    wr(6'h08, 8'h03);
    chk({7'b0, cmd_err}, 8'h01, "R10 rx reserved pulse");
    chk({7'b0, rx_accept}, 8'h00, "R10 rx stays disabled");
    // R9 push while disabled ignored
    push(8'h11);
    rd(6'h04, 8'h0C, "R9 disabled push dropped");
    // R3 FIFO
    wr(6'h08, 8'h01);
    chk({7'b0, rx_accept}, 8'h01, "R9 accept");
    wr(6'h14, 8'h02);
    push(8'h11); push(8'h22);
    rd(6'h04, 8'h0D, "R3 ready");
    chk({7'b0, irq}, 8'h01, "R8 rx irq");
    rd(6'h14, 8'h03, "R7 ready source");
    push(8'h33); push(8'h44);
    rd(6'h04, 8'h0F, "R3 full");
    chk({7'b0, rx_accept}, 8'h00, "R9 full no accept");
    push(8'h55);
    rd(6'h0C, 8'h11, "R3 pop1");
    rd(6'h04, 8'h0D, "R3 not full");
    rd(6'h0C, 8'h22, "R3 pop2");
    rd(6'h0C, 8'h33, "R3 pop3");
    rd(6'h0C, 8'h44, "R9 pop4 no 55");
    rd(6'h04, 8'h0C, "R3 drained");
    rd(6'h0C, 8'h00, "R3 empty read");
    chk({7'b0, irq}, 8'h00, "R8 rx irq gone");
    // R7 full-select mode
    wr(6'h00, 8'h40);
    push(8'h66); push(8'h77);
    rd(6'h14, 8'h01, "R7 full select partial");
    chk({7'b0, irq}, 8'h00, "R7 no irq partial");
    push(8'h88); push(8'h99);
    rd(6'h14, 8'h03, "R7 full select full");
    chk({7'b0, irq}, 8'h01, "R7 irq full");
    // R5 receiver reset
    wr(6'h08, 8'h20);
    rd(6'h04, 8'h0C, "R5 rx reset status");
    rd(6'h14, 8'h01, "R5 rx reset isr");
    chk({7'b0, rx_accept}, 8'h00, "R5 rx disabled");
    // R11 break
    brk();
    rd(6'h14, 8'h05, "R11 break flag");
    rd(6'h04, 8'h0D, "R11 break byte");
    wr(6'h08, 8'h01);
    push(8'hA1); push(8'hA2); push(8'hA3);
    brk();
    rd(6'h0C, 8'h00, "R11 pop1");
    rd(6'h0C, 8'hA1, "R11 pop2");
    rd(6'h0C, 8'hA2, "R11 pop3");
    rd(6'h0C, 8'h00, "R11 overwrite");
    wr(6'h08, 8'h50);
    rd(6'h14, 8'h01, "R5 break clear");
    wr(6'h08, 8'h40);
    rd(6'h04, 8'h0C, "R5 code4 no effect");
    // R12 baud, ignored writes, unmapped
    wr(6'h18, 8'h12);
    wr(6'h1C, 8'h34);
    rd(6'h18, 8'h12, "R12 baud hi");
    rd(6'h1C, 8'h34, "R12 baud lo");
    wr(6'h04, 8'hFF);
    wr(6'h10, 8'hFF);
    rd(6'h04, 8'h0C, "R12 status write ignored");
    rd(6'h10, 8'h00, "R12 aux reads zero");
    rd(6'h20, 8'h00, "R12 unmapped");
    rd(6'h00, 8'h40, "R12 mode untouched");
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule